// File: doc/BRIEF.md
# Flash Access Security Gate

This block sits between an external programming port and an on-chip flash array of 8 KiB. Every external request (read, byte write, page erase, mass erase) goes through it. The block passes the request to the flash array, answers it itself, or refuses it. The decision depends on a security bit that lives in a configuration byte stored in the top flash location, 0x1FFF. The flash array is reached through a small command port that handshakes with a single-cycle acknowledge.

After reset the gate fetches the configuration byte from the array before it accepts any request, so the stored security state takes effect at once. In operation it keeps a live copy of the security bit and of a "configuration already programmed" flag. It updates both when a configuration write, an erase of the last page, or a mass erase completes. Bit 3 of the configuration byte holds the security setting, and the value 0 means secured. An erased byte (0xFF) therefore leaves the part open, which agrees with mass erase being the way to remove protection.

The controller steps through five states. `ST_BOOT` holds a read of 0x1FFF until the acknowledge arrives, then moves to `ST_IDLE`. `ST_IDLE` raises ready. When a request is taken it moves to `ST_LOCAL` if the gate answers the request itself, or to `ST_ISSUE` if the request goes to the flash array. `ST_LOCAL` gives a one-cycle response and returns to `ST_IDLE`. `ST_ISSUE` holds the flash command until the acknowledge arrives, then moves to `ST_DONE`. `ST_DONE` gives a one-cycle response and returns to `ST_IDLE`.

Top module: `flash_sec_gate`

## Requirements
- R1: After reset, `req_ready` stays low while the gate reads array address 0x1FFF. The gate takes the security state from bit 3 of that byte (0 = secured) before it accepts the first request.
- R2: While unsecured, a read of 0x0000–0x1FFF is sent to the array and returns the stored byte. A byte write to that range is sent to the array unless rule R9 refuses it.
- R3: While secured, a read of 0x0000–0x1FFF (including 0x1FFF itself) returns 0xFF with `rsp_rejected` low. The response comes one cycle after acceptance, and no array command is issued.
- R4: A read of 0xFFFF is sent to the array as a read of 0x1FFF and returns the configuration byte, in either security state.
- R5: A read of 0x2000–0xFFFE returns 0xFF with `rsp_rejected` low and issues no array command.
- R6: While secured, every byte write is refused, including a write to 0x1FFF.
- R7: While secured, every page erase is refused.
- R8: A mass erase is always sent to the array (command code 3). Once it completes, the part is unsecured and the configuration byte can be written again.
- R9: A write to 0x1FFF is accepted only while the configuration byte is unprogrammed. After one write, further writes to it are refused until the last page (0x1FC0–0x1FFF) has been erased.
- R10: A completed write to 0x1FFF applies its bit 3 to the very next request.
- R11: A page erase sends the page base to the array: `fl_addr` = {addr[12:6], 6'b0}, command code 2.
- R12: Byte writes and page erases to addresses above 0x1FFF, including 0xFFFF, are refused.
- R13: A refused request, or a request the gate answers itself, raises `rsp_done` one cycle after acceptance and issues no array command. A request sent to the array raises `rsp_done` in the cycle after `fl_ack`. The array command stays stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate can take a request |
| req_op | input | 2 | 0 read, 1 byte write, 2 page erase, 3 mass erase |
| req_addr | input | 16 | External address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rejected | output | 1 | Request was refused (valid with `rsp_done`) |
| rsp_rdata | output | 8 | Read result (valid with `rsp_done`) |
| fl_cmd_valid | output | 1 | Array command pending |
| fl_cmd | output | 2 | Array command, same coding as `req_op` |
| fl_addr | output | 13 | Array byte address |
| fl_wdata | output | 8 | Array write byte |
| fl_ack | input | 1 | Array finished the command (one cycle) |
| fl_rdata | input | 8 | Array read byte, valid with `fl_ack` |

## Verification
The hardest condition to reach is the lock on the configuration byte being released, which happens only after an erase of the last page. The stimulus first programs the byte, confirms that a second write is refused, and then erases 0x1FC5. It checks that the neighbouring page keeps its data, and then programs a secured value that must take effect on the next read. A second reset with that secured byte in the array checks that the boot fetch restores the protection, and a mass erase then has to remove it again.

// File: rtl/fgate_pkg.sv
package fgate_pkg;

    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_WRITE      = 2'd1,
        OP_PAGE_ERASE = 2'd2,
        OP_MASS_ERASE = 2'd3
    } fg_op_e;

    typedef enum logic [1:0] {
        ACT_FLASH  = 2'd0,
        ACT_FILL   = 2'd1,
        ACT_REFUSE = 2'd2
    } fg_act_e;

    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_LOCAL = 3'd2,
        ST_ISSUE = 3'd3,
        ST_DONE  = 3'd4
    } fg_state_e;

endpackage

// File: rtl/fgate_addr_decode.sv
module fgate_addr_decode #(
    parameter int ADDR_W  = 16,
    parameter int ARR_AW  = 13,
    parameter int PAGE_AW = 6,
    parameter logic [ADDR_W-1:0] ALIAS_ADDR = '1
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic                      in_array,
    output logic                      is_cfg,
    output logic                      is_alias,
    output logic [ARR_AW-PAGE_AW-1:0] page_idx,
    output logic                      last_page
);
    localparam int PIDX_W = ARR_AW - PAGE_AW;

    always_comb begin
        in_array  = (addr[ADDR_W-1:ARR_AW] == '0);
        is_cfg    = in_array && (addr[ARR_AW-1:0] == {ARR_AW{1'b1}});
        is_alias  = (addr == ALIAS_ADDR);
        page_idx  = addr[ARR_AW-1:PAGE_AW];
        last_page = in_array && (page_idx == {PIDX_W{1'b1}});
    end
endmodule

// File: rtl/fgate_policy.sv
module fgate_policy
    import fgate_pkg::*;
#(
    parameter int ARR_AW  = 13,
    parameter int PAGE_AW = 6
) (
    input  fg_op_e                    op,
    input  logic                      in_array,
    input  logic                      is_cfg,
    input  logic                      is_alias,
    input  logic [ARR_AW-PAGE_AW-1:0] page_idx,
    input  logic [ARR_AW-1:0]         addr_low,
    input  logic                      secured,
    input  logic                      cfg_locked,
    output fg_act_e                   act,
    output logic [ARR_AW-1:0]         fl_addr
);
    always_comb begin
        act     = ACT_REFUSE;
        fl_addr = addr_low;
        unique case (op)
            OP_READ: begin
                if (is_alias) begin
                    act     = ACT_FLASH;
                    fl_addr = {ARR_AW{1'b1}};
                end else if (in_array && !secured) begin
                    act = ACT_FLASH;
                end else begin
                    act = ACT_FILL;
                end
            end
            OP_WRITE: begin
                if (in_array && !secured && !(is_cfg && cfg_locked))
                    act = ACT_FLASH;
            end
            OP_PAGE_ERASE: begin
                if (in_array && !secured) begin
                    act     = ACT_FLASH;
                    fl_addr = {page_idx, {PAGE_AW{1'b0}}};
                end
            end
            OP_MASS_ERASE: begin
                act     = ACT_FLASH;
                fl_addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/fgate_sec_track.sv
module fgate_sec_track
    import fgate_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SEC_BIT   = 3,
    parameter bit SEC_LEVEL = 1'b0,
    parameter logic [DATA_W-1:0] ERASED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_load,
    input  logic [DATA_W-1:0] boot_word,
    input  logic              upd_en,
    input  fg_op_e            upd_op,
    input  logic              upd_cfg,
    input  logic              upd_last_page,
    input  logic [DATA_W-1:0] upd_wdata,
    output logic              secured,
    output logic              cfg_locked
);
    localparam bit ERASED_SEC = (ERASED[SEC_BIT] == SEC_LEVEL);

    logic boot_sec;
    logic wr_sec;

    generate
        if (SEC_LEVEL) begin : g_high_secures
            assign boot_sec = boot_word[SEC_BIT];
            assign wr_sec   = upd_wdata[SEC_BIT];
        end else begin : g_low_secures
            assign boot_sec = ~boot_word[SEC_BIT];
            assign wr_sec   = ~upd_wdata[SEC_BIT];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secured    <= 1'b1;
            cfg_locked <= 1'b1;
        end else if (boot_load) begin
            secured    <= boot_sec;
            cfg_locked <= (boot_word != ERASED);
        end else if (upd_en) begin
            unique case (upd_op)
                OP_WRITE: begin
                    if (upd_cfg) begin
                        secured    <= wr_sec;
                        cfg_locked <= 1'b1;
                    end
                end
                OP_PAGE_ERASE: begin
                    if (upd_last_page) begin
                        secured    <= ERASED_SEC;
                        cfg_locked <= 1'b0;
                    end
                end
                OP_MASS_ERASE: begin
                    secured    <= ERASED_SEC;
                    cfg_locked <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flash_sec_gate.sv
module flash_sec_gate
    import fgate_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ARR_AW  = 13,
    parameter int DATA_W  = 8,
    parameter int PAGE_AW = 6,
    parameter int SEC_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_rejected,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fl_cmd_valid,
    output logic [1:0]        fl_cmd,
    output logic [ARR_AW-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_ack,
    input  logic [DATA_W-1:0] fl_rdata
);
    localparam int PIDX_W = ARR_AW - PAGE_AW;
    localparam logic [ARR_AW-1:0] CFG_LOC = {ARR_AW{1'b1}};

    fg_state_e state_q, state_d;

    logic              in_array, is_cfg, is_alias, last_page;
    logic [PIDX_W-1:0] page_idx;
    fg_act_e           act_d;
    logic [ARR_AW-1:0] pol_addr;
    logic              sec_q, lock_q;
    fg_op_e            op_in;

    fg_act_e           act_q;
    fg_op_e            op_q;
    logic [ARR_AW-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              cfg_q, last_q;
    logic [DATA_W-1:0] rdata_q;

    logic accept;
    logic boot_load;
    logic upd_en;

    assign op_in     = fg_op_e'(req_op);
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign boot_load = (state_q == ST_BOOT) && fl_ack;
    assign upd_en    = (state_q == ST_ISSUE) && fl_ack;

    fgate_addr_decode #(
        .ADDR_W (ADDR_W),
        .ARR_AW (ARR_AW),
        .PAGE_AW(PAGE_AW)
    ) i_decode (
        .addr     (req_addr),
        .in_array (in_array),
        .is_cfg   (is_cfg),
        .is_alias (is_alias),
        .page_idx (page_idx),
        .last_page(last_page)
    );

    fgate_policy #(
        .ARR_AW (ARR_AW),
        .PAGE_AW(PAGE_AW)
    ) i_policy (
        .op        (op_in),
        .in_array  (in_array),
        .is_cfg    (is_cfg),
        .is_alias  (is_alias),
        .page_idx  (page_idx),
        .addr_low  (req_addr[ARR_AW-1:0]),
        .secured   (sec_q),
        .cfg_locked(lock_q),
        .act       (act_d),
        .fl_addr   (pol_addr)
    );

    fgate_sec_track #(
        .DATA_W (DATA_W),
        .SEC_BIT(SEC_BIT)
    ) i_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_load    (boot_load),
        .boot_word    (fl_rdata),
        .upd_en       (upd_en),
        .upd_op       (op_q),
        .upd_cfg      (cfg_q),
        .upd_last_page(last_q),
        .upd_wdata    (wdata_q),
        .secured      (sec_q),
        .cfg_locked   (lock_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  if (fl_ack) state_d = ST_IDLE;
            ST_IDLE:  if (req_valid) state_d = (act_d == ACT_FLASH) ? ST_ISSUE : ST_LOCAL;
            ST_LOCAL: state_d = ST_IDLE;
            ST_ISSUE: if (fl_ack) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_BOOT;
        endcase
    end

    // Request capture and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= ACT_REFUSE;
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            cfg_q   <= 1'b0;
            last_q  <= 1'b0;
            rdata_q <= '1;
        end else begin
            if (accept) begin
                act_q   <= act_d;
                op_q    <= op_in;
                addr_q  <= pol_addr;
                wdata_q <= req_wdata;
                cfg_q   <= is_cfg;
                last_q  <= last_page;
            end
            if (upd_en)
                rdata_q <= (op_q == OP_READ) ? fl_rdata : '1;
        end
    end

    // Outputs
    always_comb begin
        req_ready    = 1'b0;
        rsp_done     = 1'b0;
        rsp_rejected = 1'b0;
        rsp_rdata    = '1;
        fl_cmd_valid = 1'b0;
        fl_cmd       = OP_READ;
        fl_addr      = '0;
        fl_wdata     = '0;
        unique case (state_q)
            ST_BOOT: begin
                fl_cmd_valid = 1'b1;
                fl_cmd       = OP_READ;
                fl_addr      = CFG_LOC;
            end
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_LOCAL: begin
                rsp_done     = 1'b1;
                rsp_rejected = (act_q == ACT_REFUSE);
            end
            ST_ISSUE: begin
                fl_cmd_valid = 1'b1;
                fl_cmd       = op_q;
                fl_addr      = addr_q;
                fl_wdata     = wdata_q;
            end
            ST_DONE: begin
                rsp_done  = 1'b1;
                rsp_rdata = rdata_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fgate_checker.sv
module fgate_checker
    import fgate_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ARR_AW = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_done,
    input logic              rsp_rejected,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              fl_cmd_valid,
    input logic [1:0]        fl_cmd,
    input logic [ARR_AW-1:0] fl_addr,
    input logic              fl_ack,
    input logic              secured,
    input fg_state_e         state
);
    logic boot_seen;
    logic take;

    assign take = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      boot_seen <= 1'b0;
        else if (fl_ack) boot_seen <= 1'b1;
    end

    // R1
    boot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_seen |-> !req_ready);

    // R3
    secured_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == OP_READ && secured && req_addr[ADDR_W-1:ARR_AW] == '0)
        |=> (rsp_done && !rsp_rejected && rsp_rdata == '1 && !fl_cmd_valid));

    // R4
    alias_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == OP_READ && req_addr == '1)
        |=> (fl_cmd_valid && fl_cmd == OP_READ && fl_addr == '1));

    // R6
    secured_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == OP_WRITE && secured) |=> (rsp_done && rsp_rejected));

    // R8
    mass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == OP_MASS_ERASE) |=> (fl_cmd_valid && fl_cmd == OP_MASS_ERASE));

    // R11
    page_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd_valid && fl_cmd == OP_PAGE_ERASE) |-> (fl_addr[5:0] == 6'd0));

    // R13
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rejected |-> (rsp_done && !fl_cmd_valid));

    // R13
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd_valid && !fl_ack) |=> (fl_cmd_valid && $stable(fl_addr) && $stable(fl_cmd)));

    // R13
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE && fl_ack) |=> rsp_done);

    // R13
    ready_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_done && !fl_cmd_valid));
endmodule

bind flash_sec_gate fgate_checker #(
    .ADDR_W(ADDR_W),
    .ARR_AW(ARR_AW),
    .DATA_W(DATA_W)
) i_fgate_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .rsp_done    (rsp_done),
    .rsp_rejected(rsp_rejected),
    .rsp_rdata   (rsp_rdata),
    .fl_cmd_valid(fl_cmd_valid),
    .fl_cmd      (fl_cmd),
    .fl_addr     (fl_addr),
    .fl_ack      (fl_ack),
    .secured     (sec_q),
    .state       (state_q)
);

// File: tb/test_flash_sec_gate.sv
module test_flash_sec_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = 16'd0;
    logic [7:0]  req_wdata = 8'd0;
    logic        rsp_done, rsp_rejected;
    logic [7:0]  rsp_rdata;
    logic        fl_cmd_valid;
    logic [1:0]  fl_cmd;
    logic [12:0] fl_addr;
    logic [7:0]  fl_wdata;
    logic        fl_ack = 1'b0;
    logic [7:0]  fl_rdata = 8'hFF;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int ack_cnt = 0;
    int last_ack = 0;
    int fl_wait = 0;
    logic [12:0] last_pe_addr = '0;
    bit finished = 0;

    logic [7:0] mem [int];

    typedef struct {
        string      tag;
        bit         exp_rej;
        bit         chk_data;
        logic [7:0] exp_data;
        int         exp_flash;
        int         acc_cyc;
        int         ack_snap;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    flash_sec_gate i_flash_sec_gate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rejected(rsp_rejected), .rsp_rdata(rsp_rdata),
        .fl_cmd_valid(fl_cmd_valid), .fl_cmd(fl_cmd), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
    );

    function automatic logic [7:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural flash array: acknowledges on the third cycle of a command
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_ack  <= 1'b0;
            fl_wait <= 0;
        end else if (fl_ack) begin
            fl_ack <= 1'b0;
        end else if (fl_cmd_valid) begin
            if (fl_wait == 2) begin
                fl_wait <= 0;
                fl_ack  <= 1'b1;
                ack_cnt <= ack_cnt + 1;
                case (fl_cmd)
                    2'd0: fl_rdata <= rd(int'(fl_addr));
                    2'd1: mem[int'(fl_addr)] = fl_wdata;
                    2'd2: begin
                        last_pe_addr <= fl_addr;
                        for (int i = 0; i < 64; i++)
                            if (mem.exists(int'({fl_addr[12:6], 6'd0}) + i))
                                mem.delete(int'({fl_addr[12:6], 6'd0}) + i);
                    end
                    default: mem.delete();
                endcase
            end else begin
                fl_wait <= fl_wait + 1;
            end
        end
    end

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (fl_ack) last_ack = cyc;
        if (rst_n && rsp_done) begin
            if (sb.size() == 0) begin
                check("R13 unexpected done", 1'b0, 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check({it.tag, " rejected"}, rsp_rejected == it.exp_rej, rsp_rejected, it.exp_rej);
                if (it.chk_data)
                    check({it.tag, " rdata"}, rsp_rdata == it.exp_data, rsp_rdata, it.exp_data);
                check({it.tag, " flash cmds"}, (ack_cnt - it.ack_snap) == it.exp_flash,
                      ack_cnt - it.ack_snap, it.exp_flash);
                if (it.exp_flash == 0)
                    check({it.tag, " R13 local timing"}, cyc == it.acc_cyc + 1, cyc, it.acc_cyc + 1);
                else
                    check({it.tag, " R13 ack timing"}, cyc == last_ack + 1, cyc, last_ack + 1);
            end
        end
    end

    task automatic req(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                       input bit rej, input bit chkd, input logic [7:0] ed,
                       input int fl, input string tag);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = d;
        it.tag = tag; it.exp_rej = rej; it.chk_data = chkd; it.exp_data = ed;
        it.exp_flash = fl; it.acc_cyc = cyc; it.ack_snap = ack_cnt;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready low in boot", req_ready == 1'b0, req_ready, 0);
        check("R1 boot read of cfg", fl_cmd_valid && fl_cmd == 2'd0 && fl_addr == 13'h1FFF,
              fl_addr, 13'h1FFF);
        check("R1 no done in boot", rsp_done == 1'b0, rsp_done, 0);
    endtask

    initial begin
        mem[16'h0010] = 8'h5A;
        mem[16'h1FC5] = 8'h33;
        mem[16'h1FBF] = 8'h44;
        do_reset();

        req(2'd0, 16'h0010, 8'h00, 0, 1, 8'h5A, 1, "R2 open read");
        req(2'd0, 16'hFFFF, 8'h00, 0, 1, 8'hFF, 1, "R4 alias read erased");
        req(2'd0, 16'h2000, 8'h00, 0, 1, 8'hFF, 0, "R5 out of range read");
        req(2'd0, 16'hFFFE, 8'h00, 0, 1, 8'hFF, 0, "R5 top out of range read");
        req(2'd1, 16'h2000, 8'h11, 1, 0, 8'h00, 0, "R12 write out of range");
        req(2'd1, 16'hFFFF, 8'h11, 1, 0, 8'h00, 0, "R12 write alias");
        req(2'd2, 16'h8000, 8'h00, 1, 0, 8'h00, 0, "R12 erase out of range");
        req(2'd1, 16'h0020, 8'h77, 0, 0, 8'h00, 1, "R2 open write");
        req(2'd0, 16'h0020, 8'h00, 0, 1, 8'h77, 1, "R2 read back");
        req(2'd1, 16'h1FFF, 8'hAC, 0, 0, 8'h00, 1, "R9 first cfg write");
        req(2'd0, 16'hFFFF, 8'h00, 0, 1, 8'hAC, 1, "R4 alias read");
        req(2'd1, 16'h1FFF, 8'hA4, 1, 0, 8'h00, 0, "R9 second cfg write");
        req(2'd0, 16'hFFFF, 8'h00, 0, 1, 8'hAC, 1, "R9 cfg unchanged");
        req(2'd2, 16'h1FC5, 8'h00, 0, 0, 8'h00, 1, "R11 last page erase");
        check("R11 page base", last_pe_addr == 13'h1FC0, last_pe_addr, 13'h1FC0);
        req(2'd0, 16'h1FC5, 8'h00, 0, 1, 8'hFF, 1, "R11 page cleared");
        req(2'd0, 16'h1FBF, 8'h00, 0, 1, 8'h44, 1, "R11 neighbour kept");
        req(2'd1, 16'h1FFF, 8'h52, 0, 0, 8'h00, 1, "R9 cfg write after erase");
        req(2'd0, 16'h0010, 8'h00, 0, 1, 8'hFF, 0, "R10 secured at once");
        req(2'd0, 16'hFFFF, 8'h00, 0, 1, 8'h52, 1, "R4 alias while secured");
        req(2'd0, 16'h1FFF, 8'h00, 0, 1, 8'hFF, 0, "R3 physical cfg hidden");
        req(2'd1, 16'h0030, 8'h12, 1, 0, 8'h00, 0, "R6 secured write");
        req(2'd1, 16'h1FFF, 8'hFF, 1, 0, 8'h00, 0, "R6 secured cfg write");
        req(2'd2, 16'h0000, 8'h00, 1, 0, 8'h00, 0, "R7 secured page erase");
        check("R6 array untouched", rd(16'h0030) == 8'hFF, rd(16'h0030), 8'hFF);

        do_reset();
        req(2'd0, 16'h0010, 8'h00, 0, 1, 8'hFF, 0, "R1 secured after reset");
        req(2'd0, 16'h0020, 8'h00, 0, 1, 8'hFF, 0, "R3 secured read");
        req(2'd3, 16'h1234, 8'h00, 0, 0, 8'h00, 1, "R8 mass erase");
        req(2'd0, 16'h0010, 8'h00, 0, 1, 8'hFF, 1, "R8 open after mass erase");
        req(2'd1, 16'h0010, 8'h99, 0, 0, 8'h00, 1, "R8 write after mass erase");
        req(2'd0, 16'h0010, 8'h00, 0, 1, 8'h99, 1, "R8 read back");
        req(2'd1, 16'h1FFF, 8'hF7, 0, 0, 8'h00, 1, "R8 cfg writable");
        req(2'd3, 16'h0000, 8'h00, 0, 0, 8'h00, 1, "R8 mass erase while secured");
        req(2'd0, 16'hFFFF, 8'h00, 0, 1, 8'hFF, 1, "R8 cfg erased");

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog R13 actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule